// File: doc/BRIEF.md
# Nested Trap Level Controller

This block sequences trap entry and trap return for a processor core that allows traps to nest. When a trap is taken, the core presents its live condition codes, address-space identifier, processor state, window pointer, PC and next PC. The block pushes them onto a per-level stack and produces the state the core continues with. That state is privileged, FP-enabled processor state with alternate globals, an adjusted window pointer, a trap vector offset, and a PC aimed at that vector.

On return the core chooses retry or done. The block pops the most recent level and hands back the saved fields. With retry execution resumes at the saved PC. With done it resumes at the saved next PC. All results are registered and appear one cycle after the request, marked by a one-cycle update strobe. A trap that arrives while every level is already in use puts the block into a sticky error state.

Top module: `trap_nest_ctrl`

## Requirements
- R1: After reset, tl_o is 0, error_o and upd_o are 0, and every other output is 0.
- R2: An accepted entry (entry_i high, error_o low, tl_o below MAXTL) stores the live PC, next PC, condition codes, ASI, processor state and window pointer at stack index tl_o. One cycle later tl_o is one higher and upd_o is high for exactly one cycle.
- R3: After an accepted entry, pstate_o is 0x015: bit 4 is FP enable, bit 2 is privileged and bit 0 is alternate globals. When the entry was taken at tl_o equal to MAXTL-1, bit 5 (red state) is also set, giving 0x035.
- R4: After an accepted entry, cwp_o depends on tt_i. For tt_i = 0x024 (clean window) it is cwp_i-1. For tt_i[8:6] = 3'b010 (spill) it is cwp_i-cansave_i-2. For tt_i[8:6] = 3'b011 (fill) it is cwp_i+1. For any other value it is cwp_i. All results are taken modulo NWIN.
- R5: After an accepted entry, tvec_o[14] is 1 exactly when tl_o before the entry was above 1, tvec_o[13:5] equals tt_i and tvec_o[4:0] is 0. pc_o is {tba_i, tvec_o} and npc_o is pc_o+4. ccr_o and asi_o repeat ccr_i and asi_i.
- R6: A retry return (ret_i high, ret_done_i low, entry_i low, error_o low, tl_o above 0) decrements tl_o and reads stack index tl_o-1. pc_o and npc_o become the saved PC and saved next PC.
- R7: A done return (ret_done_i high, otherwise as R6) sets pc_o to the saved next PC and npc_o to the saved next PC plus 4.
- R8: Both return kinds restore ccr_o, asi_o and cwp_o from the popped level. pstate_o is restored as the saved processor state masked with 0xF3F, so bits 7:6 come back as 0. Levels pop in reverse order of entry.
- R9: A return at tl_o = 0 is ignored: upd_o stays low and all outputs keep their values.
- R10: An entry at tl_o = MAXTL sets error_o one cycle later, and error_o stays set until reset. While error_o is set, entry and return requests are ignored: upd_o stays low and all outputs hold.
- R11: When entry_i and ret_i are high in the same cycle, the entry is performed and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_i | input | 1 | Take a trap this cycle |
| tt_i | input | 9 | Trap type |
| ret_i | input | 1 | Return from trap this cycle |
| ret_done_i | input | 1 | Return kind: 1 = done, 0 = retry |
| pc_i | input | PC_W | Live PC |
| npc_i | input | PC_W | Live next PC |
| ccr_i | input | 8 | Live condition codes |
| asi_i | input | 8 | Live address-space identifier |
| pstate_i | input | 12 | Live processor state |
| cwp_i | input | CWP_W | Live window pointer |
| cansave_i | input | CWP_W | Count of windows that can be saved |
| tba_i | input | PC_W-15 | Upper part of the trap base address |
| upd_o | output | 1 | Outputs updated in this cycle |
| tl_o | output | TL_W | Current trap level |
| pc_o | output | PC_W | PC to continue at |
| npc_o | output | PC_W | Next PC to continue at |
| ccr_o | output | 8 | Condition codes to continue with |
| asi_o | output | 8 | ASI to continue with |
| pstate_o | output | 12 | Processor state to continue with |
| cwp_o | output | CWP_W | Window pointer to continue with |
| tvec_o | output | 15 | Trap vector offset of the last entry |
| error_o | output | 1 | Sticky error state |

## Verification
The error state needs the core to stack every level and then take one more trap, and the red-state bit needs an entry at exactly MAXTL-1. Uniform random stimulus tends to drift around low levels and reaches neither. The bench therefore runs a long random phase in which a bench-side model steers away from the maximum, so that returns pop real data of mixed kinds. It then drives a directed climb through every level, checks red state and the error entry, confirms that later requests are ignored, and clears the error by reset. The spill wrap with cwp_i = 0 and cansave_i = NWIN-1 is also driven directly.

// File: rtl/trap_nest_ctrl.sv
module trap_nest_ctrl #(
  parameter int PC_W  = 32,
  parameter int MAXTL = 5,
  parameter int NWIN  = 8,
  parameter int CWP_W = $clog2(NWIN),
  parameter int TL_W  = $clog2(MAXTL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               entry_i,
  input  logic [8:0]         tt_i,
  input  logic               ret_i,
  input  logic               ret_done_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    npc_i,
  input  logic [7:0]         ccr_i,
  input  logic [7:0]         asi_i,
  input  logic [11:0]        pstate_i,
  input  logic [CWP_W-1:0]   cwp_i,
  input  logic [CWP_W-1:0]   cansave_i,
  input  logic [PC_W-16:0]   tba_i,
  output logic               upd_o,
  output logic [TL_W-1:0]    tl_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    npc_o,
  output logic [7:0]         ccr_o,
  output logic [7:0]         asi_o,
  output logic [11:0]        pstate_o,
  output logic [CWP_W-1:0]   cwp_o,
  output logic [14:0]        tvec_o,
  output logic               error_o
);
  localparam int DEPTH = 1 << TL_W;
  localparam int SW_W  = 28 + CWP_W;
  localparam int XW    = CWP_W + 2;
  localparam logic [XW-1:0]   NW       = XW'(NWIN);
  localparam logic [TL_W-1:0] TL_MAX   = TL_W'(MAXTL);
  localparam logic [TL_W-1:0] TL_LAST  = TL_W'(MAXTL - 1);
  localparam logic [11:0]     PS_ENTRY = 12'h015;
  localparam logic [11:0]     PS_RED   = 12'h020;
  localparam logic [11:0]     PS_KEEP  = 12'hF3F;

  logic [SW_W-1:0] word_q [DEPTH];
  logic [PC_W-1:0] tpc_q  [DEPTH];
  logic [PC_W-1:0] tnpc_q [DEPTH];

  logic            take, fault, back;
  logic [TL_W-1:0] ridx;
  logic [SW_W-1:0] pop_w;
  logic [PC_W-1:0] pop_npc;
  logic [XW-1:0]   cw, cs, adj;
  logic [14:0]     vec;

  assign take    = entry_i && !error_o && tl_o != TL_MAX;
  assign fault   = entry_i && !error_o && tl_o == TL_MAX;
  assign back    = ret_i && !entry_i && !error_o && tl_o != '0;
  assign ridx    = tl_o - 1'b1;
  assign pop_w   = word_q[ridx];
  assign pop_npc = tnpc_q[ridx];
  assign vec     = {tl_o > TL_W'(1), tt_i, 5'b0};
  assign cw      = XW'(cwp_i);
  assign cs      = XW'(cansave_i);

  always_comb begin
    adj = cw;
    if (tt_i == 9'h024)          adj = (cw + NW - 1'b1) % NW;
    else if (tt_i[8:6] == 3'b010) adj = (cw + NW + NW - cs - XW'(2)) % NW;
    else if (tt_i[8:6] == 3'b011) adj = (cw + 1'b1) % NW;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      word_q[tl_o] <= {ccr_i, asi_i, pstate_i & PS_KEEP, cwp_i};
      tpc_q[tl_o]  <= pc_i;
      tnpc_q[tl_o] <= npc_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_o <= 1'b0; tl_o <= '0; pc_o <= '0; npc_o <= '0; ccr_o <= '0;
      asi_o <= '0; pstate_o <= '0; cwp_o <= '0; tvec_o <= '0; error_o <= 1'b0;
    end else begin
      upd_o <= take || back;
      if (fault) error_o <= 1'b1;
      if (take) begin
        tl_o     <= tl_o + 1'b1;
        pstate_o <= PS_ENTRY | ((tl_o == TL_LAST) ? PS_RED : 12'h000);
        cwp_o    <= adj[CWP_W-1:0];
        tvec_o   <= vec;
        pc_o     <= {tba_i, vec};
        npc_o    <= {tba_i, vec} + PC_W'(4);
        ccr_o    <= ccr_i;
        asi_o    <= asi_i;
      end else if (back) begin
        tl_o     <= ridx;
        ccr_o    <= pop_w[SW_W-1 -: 8];
        asi_o    <= pop_w[SW_W-9 -: 8];
        pstate_o <= pop_w[CWP_W +: 12];
        cwp_o    <= pop_w[CWP_W-1:0];
        pc_o     <= ret_done_i ? pop_npc : tpc_q[ridx];
        npc_o    <= ret_done_i ? pop_npc + PC_W'(4) : pop_npc;
      end
    end
  end
endmodule

// File: rtl/trap_nest_ctrl_chk.sv
module trap_nest_ctrl_chk #(
  parameter int PC_W  = 32,
  parameter int MAXTL = 5,
  parameter int CWP_W = 3,
  parameter int TL_W  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            entry_i,
  input logic            ret_i,
  input logic            ret_done_i,
  input logic            upd_o,
  input logic [TL_W-1:0] tl_o,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] npc_o,
  input logic [11:0]     pstate_o,
  input logic            error_o
);
  // R2
  tl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tl_o <= TL_W'(MAXTL));

  // R2
  tl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i && !error_o && tl_o != TL_W'(MAXTL) |=> tl_o == $past(tl_o) + 1'b1 && upd_o);

  // R3
  entry_pstate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i && !error_o && tl_o != TL_W'(MAXTL) |=> (pstate_o & 12'h015) == 12'h015);

  // R7
  done_npc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && ret_done_i && !entry_i && !error_o && tl_o != '0 |=> npc_o == pc_o + PC_W'(4));

  // R9
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !entry_i && tl_o == '0 |=> !upd_o && $stable(tl_o));

  // R10
  overflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i && tl_o == TL_W'(MAXTL) |=> error_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o && !upd_o);
endmodule

bind trap_nest_ctrl trap_nest_ctrl_chk #(
  .PC_W(PC_W), .MAXTL(MAXTL), .CWP_W(CWP_W), .TL_W(TL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .entry_i(entry_i), .ret_i(ret_i),
  .ret_done_i(ret_done_i), .upd_o(upd_o), .tl_o(tl_o), .pc_o(pc_o),
  .npc_o(npc_o), .pstate_o(pstate_o), .error_o(error_o)
);

// File: tb/trap_nest_ctrl_tb_top.sv
module trap_nest_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int PC_W = 32, MAXTL = 5, NWIN = 8, CWP_W = 3, TL_W = 3;

  logic clk = 0, rst_n = 0;
  logic entry_i = 0, ret_i = 0, ret_done_i = 0;
  logic [8:0] tt_i = 0;
  logic [PC_W-1:0] pc_i = 0, npc_i = 0;
  logic [7:0] ccr_i = 0, asi_i = 0;
  logic [11:0] pstate_i = 0;
  logic [CWP_W-1:0] cwp_i = 0, cansave_i = 0;
  logic [PC_W-16:0] tba_i = 0;
  logic upd_o, error_o;
  logic [TL_W-1:0] tl_o;
  logic [PC_W-1:0] pc_o, npc_o;
  logic [7:0] ccr_o, asi_o;
  logic [11:0] pstate_o;
  logic [CWP_W-1:0] cwp_o;
  logic [14:0] tvec_o;

  trap_nest_ctrl #(.PC_W(PC_W), .MAXTL(MAXTL), .NWIN(NWIN)) dut_i (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench model
  int m_tl; bit m_err, m_upd;
  logic [PC_W-1:0] m_pc, m_npc;
  logic [7:0] m_ccr, m_asi;
  logic [11:0] m_pst;
  logic [CWP_W-1:0] m_cwp;
  logic [14:0] m_vec;
  logic [PC_W-1:0] s_pc [MAXTL], s_npc [MAXTL];
  logic [7:0] s_ccr [MAXTL], s_asi [MAXTL];
  logic [11:0] s_pst [MAXTL];
  logic [CWP_W-1:0] s_cwp [MAXTL];

  function automatic logic [CWP_W-1:0] exp_cwp(logic [8:0] tt, int c, int cs);
    int r = c;
    if (tt == 9'h024) r = c - 1;
    else if (tt[8:6] == 3'b010) r = c - cs - 2;
    else if (tt[8:6] == 3'b011) r = c + 1;
    r = ((r % NWIN) + NWIN) % NWIN;
    return CWP_W'(r);
  endfunction

  task automatic model_reset();
    m_tl = 0; m_err = 0; m_upd = 0; m_pc = 0; m_npc = 0; m_ccr = 0;
    m_asi = 0; m_pst = 0; m_cwp = 0; m_vec = 0;
  endtask

  task automatic model_step();
    m_upd = 0;
    if (entry_i && !m_err) begin
      if (m_tl == MAXTL) m_err = 1;
      else begin
        s_pc[m_tl] = pc_i; s_npc[m_tl] = npc_i; s_ccr[m_tl] = ccr_i;
        s_asi[m_tl] = asi_i; s_pst[m_tl] = pstate_i & 12'hF3F; s_cwp[m_tl] = cwp_i;
        m_vec = {m_tl > 1, tt_i, 5'b0};
        m_pst = (m_tl == MAXTL - 1) ? 12'h035 : 12'h015;
        m_cwp = exp_cwp(tt_i, int'(cwp_i), int'(cansave_i));
        m_pc = {tba_i, m_vec}; m_npc = m_pc + 4;
        m_ccr = ccr_i; m_asi = asi_i;
        m_tl++; m_upd = 1;
      end
    end else if (ret_i && !m_err && m_tl > 0) begin
      m_tl--; m_upd = 1;
      m_ccr = s_ccr[m_tl]; m_asi = s_asi[m_tl]; m_pst = s_pst[m_tl]; m_cwp = s_cwp[m_tl];
      if (ret_done_i) begin m_pc = s_npc[m_tl]; m_npc = s_npc[m_tl] + 4; end
      else begin m_pc = s_pc[m_tl]; m_npc = s_npc[m_tl]; end
    end
  endtask

  task automatic check_all(string tag);
    logic [127:0] act, exp_v;
    act   = {upd_o, 5'(tl_o), error_o, pc_o, npc_o, ccr_o, asi_o, pstate_o, 5'(cwp_o), tvec_o};
    exp_v = {m_upd, 5'(m_tl), m_err, m_pc, m_npc, m_ccr, m_asi, m_pst, 5'(m_cwp), m_vec};
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // drive one cycle of request, then check after the edge
  task automatic step(bit en, bit rt, bit dn, logic [8:0] tt, string tag);
    entry_i = en; ret_i = rt; ret_done_i = dn; tt_i = tt;
    pc_i = $urandom; npc_i = $urandom; ccr_i = 8'($urandom); asi_i = 8'($urandom);
    pstate_i = 12'($urandom); cwp_i = CWP_W'($urandom % NWIN);
    cansave_i = CWP_W'($urandom % NWIN); tba_i = (PC_W-15)'($urandom);
    model_step();
    @(negedge clk);
    entry_i = 0; ret_i = 0;
    check_all(tag);
  endtask

  function automatic logic [8:0] rand_tt();
    case ($urandom % 4)
      0: return 9'h024;
      1: return {3'b010, 6'($urandom)};
      2: return {3'b011, 6'($urandom)};
      default: return 9'($urandom);
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 0; entry_i = 0; ret_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; model_reset();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    check_all("R1 reset state");

    step(0, 1, 0, 0, "R9 return at level zero ignored");
    step(0, 1, 1, 0, "R9 done at level zero ignored");

    // directed window and vector corners
    entry_i = 1; tt_i = 9'h0a5; cwp_i = 0; cansave_i = CWP_W'(NWIN - 1);
    pc_i = 32'h1000; npc_i = 32'h1004; ccr_i = 8'h5a; asi_i = 8'h80;
    pstate_i = 12'hFFF; tba_i = '1;
    model_step(); @(negedge clk); entry_i = 0;
    check_all("R4 spill wrap cwp0 cansave max, R5 vector at level 0");
    step(1, 0, 0, 9'h024, "R4 clean window, R5 level 1");
    step(1, 0, 0, 9'h0c3, "R4 fill, R5 bit14 above level 1");
    step(1, 1, 0, 9'h011, "R11 entry beats return, R4 other type");
    step(1, 0, 0, 9'h022, "R3 red state at MAXTL-1");
    step(0, 1, 0, 0, "R6 retry pop");
    step(0, 1, 1, 0, "R7 done pop");
    step(0, 1, 0, 0, "R8 restore masked state");
    step(0, 1, 1, 0, "R8 lifo order");
    step(0, 1, 0, 0, "R8 pop first level with mask");
    step(0, 1, 0, 0, "R9 return after emptying");

    // random phase steered away from the maximum level
    for (int i = 0; i < 3000; i++) begin
      bit en, rt, dn;
      en = ($urandom % 100) < 45;
      rt = ($urandom % 100) < 50;
      dn = 1'($urandom);
      if (m_tl >= MAXTL - 1 && en) en = 0;
      if (($urandom % 10) == 0) step(0, 0, 0, 0, "R9 idle holds");
      else if (en && rt) step(1, 1, dn, rand_tt(), "R11 random collision");
      else if (en) step(1, 0, 0, rand_tt(), "R2 random entry");
      else if (rt && dn) step(0, 1, 1, 0, "R7 random done");
      else if (rt) step(0, 1, 0, 0, "R6 random retry");
      else step(0, 0, 0, 0, "R9 idle holds");
    end

    // climb to the top, overflow into error
    while (m_tl < MAXTL) step(1, 0, 0, rand_tt(), "R2 climb to max");
    step(1, 0, 0, 9'h041, "R10 entry at max sets error");
    step(0, 1, 1, 0, "R10 return ignored in error");
    step(1, 0, 0, 9'h024, "R10 entry ignored in error");
    step(0, 0, 0, 0, "R10 error stays set");
    do_reset();
    check_all("R1 R10 reset clears error");
    step(1, 0, 0, 9'h0c0, "R2 entry after reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule